// File: doc/BRIEF.md
# I2C Master Bus-Condition Sequencer

This block holds the control register of an I2C master and decides when START, repeated START and STOP conditions may be placed on the bus. Software writes the register to enable the master, request conditions and set a few plain configuration bits. The sequencer watches whether a transmit byte is waiting, whether the bit engine is still busy with a byte and its acknowledge slot, and whether a STOP is still outstanding. It then hands one condition command at a time to the bit-level engine over a valid/ready handshake.

The engine reports completion of each condition with `cond_done`. It also reports the end of a data byte with `byte_done` and the end of the following acknowledge slot with `ack_done`. When the engine sees a not-acknowledge in master mode and nothing else is pending, the sequencer latches a NAK flag. A START request made while this device is being addressed as a slave is refused and reported with a one-cycle arbitration-lost pulse.

Top module: `i2c_cond_seq`

## Requirements
- R1: After a synchronous reset, `ctl_q` is 0x00, `cmd_valid` is 0 and `arb_lost` is 0.
- R2: The register layout is: bit 7 enable, bit 6 start request, bit 5 stop request, bit 4 baud-interrupt enable, bit 3 transmit-interrupt enable, bit 2 NAK flag, bit 1 flush, bit 0 filter enable. Bits 7, 4, 3, 1 and 0 take the written value on every write, and `ctl_q` shows the stored register.
- R3: Bits 6, 5 and 2 can only be set by software. Writing 0 to any of them while it is 1 leaves it at 1.
- R4: A pending START is not issued while both `tx_hold_full` and `shift_full` are 0. It is issued once either of them is 1.
- R5: A start request made while the bus is already owned is issued as RESTART (`cmd_kind` 1). It is issued only after `byte_active` is low and, following a `byte_done`, an `ack_done` has been seen. A start request made on an idle bus is issued as START (`cmd_kind` 0).
- R6: While a stop request is pending, STOP (`cmd_kind` 2) is issued first. A start request that is also pending goes out only after the STOP's `cond_done`.
- R7: `cond_done` of a START or RESTART clears bit 6, and `cond_done` of a STOP clears bit 5. A write with bit 7 equal to 0 clears bits 6 and 5, and `cmd_valid` is 0 from the edge that stores that write. Start and stop cannot be set while enable is 0.
- R8: If a write sets start while bit 6 is 0 and `slave_active` is 1, bit 6 stays 0 and `arb_lost` is 1 for exactly the next cycle.
- R9: While the bus is owned and neither start nor stop is pending, `nak_event` sets bit 2. `nak_event` has no effect when the bus is idle. Any write with bit 6 or bit 5 equal to 1 clears bit 2.
- R10: Once `cmd_valid` is raised, it stays high with `cmd_kind` unchanged until `cmd_ready` is seen. No further command is raised until `cond_done` for the accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Stored control register |
| tx_hold_full | input | 1 | Transmit holding register has a byte |
| shift_full | input | 1 | Shift register has a byte |
| slave_active | input | 1 | Slave transaction addressed to this device in progress |
| byte_active | input | 1 | Engine is shifting a data byte |
| byte_done | input | 1 | Pulse: data byte finished, acknowledge slot follows |
| ack_done | input | 1 | Pulse: acknowledge slot finished |
| nak_event | input | 1 | Pulse: not-acknowledge sent or received |
| cmd_valid | output | 1 | Condition command offered to the engine |
| cmd_kind | output | 2 | 0 START, 1 RESTART, 2 STOP |
| cmd_ready | input | 1 | Engine accepts the offered command |
| cond_done | input | 1 | Pulse: accepted condition has been placed on the bus |
| arb_lost | output | 1 | One-cycle pulse: start refused because of slave traffic |

## Verification
A wrong sequencer state shows up at `cmd_valid` and `cmd_kind` one edge after the inputs that should or should not have released a condition. Examples are a START offered with no data, a RESTART offered inside an acknowledge slot, or a START that overtakes a pending STOP. A wrong register update is visible on `ctl_q` in the cycle after the write or completion pulse. This applies to a request bit that clears too early, that survives a disable, or a NAK flag that sets on an idle bus. Each bench step therefore compares all outputs one edge after its inputs are applied.

// File: rtl/i2c_cond_seq_pkg.sv
package i2c_cond_seq_pkg;

    localparam int CTL_W = 8;

    // Control register layout, most significant bit first
    typedef struct packed {
        logic en;
        logic start;
        logic stop;
        logic baud_ie;
        logic tx_ie;
        logic nak;
        logic flush;
        logic filt;
    } ctl_s;

    typedef enum logic [1:0] {
        COND_START   = 2'd0,
        COND_RESTART = 2'd1,
        COND_STOP    = 2'd2
    } cond_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_OWNED,
        SQ_ISSUE,
        SQ_WAIT
    } seq_state_e;

    function automatic cond_e start_kind(input logic owned);
        return owned ? COND_RESTART : COND_START;
    endfunction

endpackage

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
    import i2c_cond_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  ctl_s wdata,
    input  logic slave_active,
    input  logic nak_event,
    input  logic master,
    input  logic start_done,
    input  logic stop_done,
    output ctl_s ctl,
    output logic abort,
    output logic arb_lost
);

    ctl_s q, nxt;
    logic reject;

    assign abort = wr ? !wdata.en : !q.en;

    always_comb begin
        nxt    = q;
        reject = 1'b0;
        if (wr) begin
            nxt.en      = wdata.en;
            nxt.baud_ie = wdata.baud_ie;
            nxt.tx_ie   = wdata.tx_ie;
            nxt.flush   = wdata.flush;
            nxt.filt    = wdata.filt;
            if (wdata.start) begin
                if (!q.start && slave_active) reject    = 1'b1;
                else                          nxt.start = 1'b1;
            end
            if (wdata.stop) nxt.stop = 1'b1;
            if (wdata.nak)  nxt.nak  = 1'b1;
        end
        if (start_done) nxt.start = 1'b0;
        if (stop_done)  nxt.stop  = 1'b0;
        if (nak_event && master && !q.start && !q.stop) nxt.nak = 1'b1;
        if (wr && (wdata.start || wdata.stop)) nxt.nak = 1'b0;
        if (!nxt.en) begin
            nxt.start = 1'b0;
            nxt.stop  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            arb_lost <= 1'b0;
        end else begin
            q        <= nxt;
            arb_lost <= reject;
        end
    end

    assign ctl = q;

    // R3
    start_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q.start && !start_done && !abort) |=> q.start);

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q.stop && !stop_done && !abort) |=> q.stop);

    // R8
    arb_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        arb_lost |-> !q.start);

endmodule

// File: rtl/i2c_phase_track.sv
module i2c_phase_track (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic byte_active,
    input  logic byte_done,
    input  logic ack_done,
    output logic busy
);

    logic ack_pend;

    always_ff @(posedge clk) begin
        if (rst || abort)   ack_pend <= 1'b0;
        else if (byte_done) ack_pend <= 1'b1;
        else if (ack_done)  ack_pend <= 1'b0;
    end

    assign busy = byte_active || byte_done || ack_pend;

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_cond_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  abort,
    input  logic  start_req,
    input  logic  stop_req,
    input  logic  has_data,
    input  logic  busy,
    input  logic  cmd_ready,
    input  logic  cond_done,
    output logic  cmd_valid,
    output cond_e cmd_kind,
    output logic  master,
    output logic  start_done,
    output logic  stop_done
);

    seq_state_e st, st_n;
    cond_e      kind_q, kind_n;
    logic       at_rest;

    assign at_rest = (st == SQ_IDLE) || (st == SQ_OWNED);

    always_comb begin
        st_n   = st;
        kind_n = kind_q;
        if (abort) begin
            st_n = SQ_IDLE;
        end else begin
            case (st)
                SQ_IDLE, SQ_OWNED: begin
                    if (stop_req && !busy) begin
                        st_n   = SQ_ISSUE;
                        kind_n = COND_STOP;
                    end else if (start_req && has_data && !busy) begin
                        st_n   = SQ_ISSUE;
                        kind_n = start_kind(st == SQ_OWNED);
                    end
                end
                SQ_ISSUE: if (cmd_ready) st_n = SQ_WAIT;
                SQ_WAIT: begin
                    if (cond_done)
                        st_n = (kind_q == COND_STOP) ? SQ_IDLE : SQ_OWNED;
                end
                default: st_n = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            kind_q <= COND_START;
        end else begin
            st     <= st_n;
            kind_q <= kind_n;
        end
    end

    assign cmd_valid  = (st == SQ_ISSUE);
    assign cmd_kind   = kind_q;
    assign master     = (st == SQ_OWNED);
    assign start_done = (st == SQ_WAIT) && cond_done && (kind_q != COND_STOP);
    assign stop_done  = (st == SQ_WAIT) && cond_done && (kind_q == COND_STOP);

    // R10
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && !abort) |=> (cmd_valid && $stable(cmd_kind)));

    // R5
    no_offer_in_byte_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) |-> $past(!busy));

    // R10
    single_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (at_rest == 1'b0 && !cmd_valid && !cond_done && !abort) |=> !cmd_valid);

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    input  logic             tx_hold_full,
    input  logic             shift_full,
    input  logic             slave_active,
    input  logic             byte_active,
    input  logic             byte_done,
    input  logic             ack_done,
    input  logic             nak_event,
    output logic             cmd_valid,
    output logic [1:0]       cmd_kind,
    input  logic             cmd_ready,
    input  logic             cond_done,
    output logic             arb_lost
);

    ctl_s  ctl;
    cond_e kind;
    logic  abort, busy, master, start_done, stop_done;

    i2c_ctl_reg u_reg (
        .clk          (clk),
        .rst          (rst),
        .wr           (ctl_wr),
        .wdata        (ctl_s'(ctl_wdata)),
        .slave_active (slave_active),
        .nak_event    (nak_event),
        .master       (master),
        .start_done   (start_done),
        .stop_done    (stop_done),
        .ctl          (ctl),
        .abort        (abort),
        .arb_lost     (arb_lost)
    );

    i2c_phase_track u_phase (
        .clk         (clk),
        .rst         (rst),
        .abort       (abort),
        .byte_active (byte_active),
        .byte_done   (byte_done),
        .ack_done    (ack_done),
        .busy        (busy)
    );

    i2c_cond_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .abort      (abort),
        .start_req  (ctl.start),
        .stop_req   (ctl.stop),
        .has_data   (tx_hold_full || shift_full),
        .busy       (busy),
        .cmd_ready  (cmd_ready),
        .cond_done  (cond_done),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (kind),
        .master     (master),
        .start_done (start_done),
        .stop_done  (stop_done)
    );

    assign ctl_q    = ctl;
    assign cmd_kind = kind;

    // R6
    stop_backed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind == COND_STOP) |-> ctl.stop);

    // R4
    start_backed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind != COND_STOP) |-> ctl.start);

    // R7
    enabled_offer_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ctl.en);

endmodule

// File: tb/i2c_cond_seq_tb.sv
`timescale 1ns/1ps
module i2c_cond_seq_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       ctl_wr = 0, tx_hold_full = 0, shift_full = 0, slave_active = 0;
    logic       byte_active = 0, byte_done = 0, ack_done = 0, nak_event = 0;
    logic       cmd_ready = 0, cond_done = 0;
    logic [7:0] ctl_wdata = 0, ctl_q;
    logic       cmd_valid, arb_lost;
    logic [1:0] cmd_kind;

    i2c_cond_seq dut_i (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .tx_hold_full(tx_hold_full), .shift_full(shift_full), .slave_active(slave_active),
        .byte_active(byte_active), .byte_done(byte_done), .ack_done(ack_done),
        .nak_event(nak_event), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_ready(cmd_ready), .cond_done(cond_done), .arb_lost(arb_lost)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       wr;
        logic [7:0] wd;
        logic       txf, shf, bact, bdone, adone, rdy, cdone, slv, nak;
        logic [7:0] ectl;
        logic       ev;
        logic [1:0] ek;
        logic       earb;
    } vec_t;

    localparam int NV = 30;
    // fields: req, wr, wd, txf, shf, bact, bdone, adone, rdy, cdone, slv, nak, ectl, ev, ek, earb
    localparam vec_t TBL [NV] = '{
        '{4'd2, 1'b1, 8'h80, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80, 1'b0, 2'd0, 1'b0}, // R2 enable
        '{4'd4, 1'b1, 8'hC0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b0, 2'd0, 1'b0}, // R4 request
        '{4'd4, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b0, 2'd0, 1'b0}, // R4 no data
        '{4'd4, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b1, 2'd0, 1'b0}, // R4 data
        '{4'd10,1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b1, 2'd0, 1'b0}, // R10 hold
        '{4'd10,1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hC0, 1'b0, 2'd0, 1'b0}, // R10 accept
        '{4'd7, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h80, 1'b0, 2'd0, 1'b0}, // R7 done
        '{4'd5, 1'b1, 8'hC0, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b0, 2'd0, 1'b0}, // R5 shifting
        '{4'd5, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b0, 2'd0, 1'b0}, // R5 byte end
        '{4'd5, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b0, 2'd0, 1'b0}, // R5 ack slot
        '{4'd5, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b0, 2'd0, 1'b0}, // R5 ack end
        '{4'd5, 1'b0, 8'h00, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b1, 2'd1, 1'b0}, // R5 restart
        '{4'd10,1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hC0, 1'b0, 2'd0, 1'b0}, // R10 accept
        '{4'd7, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h80, 1'b0, 2'd0, 1'b0}, // R7 done
        '{4'd9, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h84, 1'b0, 2'd0, 1'b0}, // R9 set
        '{4'd9, 1'b1, 8'hA0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hA0, 1'b0, 2'd0, 1'b0}, // R9 clear
        '{4'd6, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hA0, 1'b1, 2'd2, 1'b0}, // R6 stop
        '{4'd6, 1'b1, 8'hE0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hE0, 1'b1, 2'd2, 1'b0}, // R6 both
        '{4'd6, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hE0, 1'b0, 2'd0, 1'b0}, // R6 accept
        '{4'd6, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'hC0, 1'b0, 2'd0, 1'b0}, // R6 stop done
        '{4'd6, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0, 1'b1, 2'd0, 1'b0}, // R6 start next
        '{4'd7, 1'b1, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 1'b0, 2'd0, 1'b0}, // R7 disable
        '{4'd2, 1'b1, 8'h80, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80, 1'b0, 2'd0, 1'b0}, // R2 enable
        '{4'd8, 1'b1, 8'hC0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h80, 1'b0, 2'd0, 1'b1}, // R8 refuse
        '{4'd8, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80, 1'b0, 2'd0, 1'b0}, // R8 pulse end
        '{4'd9, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h80, 1'b0, 2'd0, 1'b0}, // R9 idle bus
        '{4'd3, 1'b1, 8'h84, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h84, 1'b0, 2'd0, 1'b0}, // R3 set nak
        '{4'd3, 1'b1, 8'h80, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h84, 1'b0, 2'd0, 1'b0}, // R3 zero kept
        '{4'd2, 1'b1, 8'h9B, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h9F, 1'b0, 2'd0, 1'b0}, // R2 plain bits
        '{4'd7, 1'b1, 8'h40, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 1'b0, 2'd0, 1'b0}  // R7 no start w/o en
    };

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input string rq, input logic [7:0] ectl, input logic ev,
                         input logic [1:0] ek, input logic earb);
        n_chk++;
        if (ctl_q !== ectl || cmd_valid !== ev || arb_lost !== earb || (ev && cmd_kind !== ek)) begin
            n_bad++;
            $display("FAIL %s: ctl=%02h valid=%0b kind=%0d arb=%0b expected ctl=%02h valid=%0b kind=%0d arb=%0b",
                     rq, ctl_q, cmd_valid, cmd_kind, arb_lost, ectl, ev, ek, earb);
        end
    endtask

    task automatic drive(input vec_t v);
        ctl_wr = v.wr; ctl_wdata = v.wd; tx_hold_full = v.txf; shift_full = v.shf;
        byte_active = v.bact; byte_done = v.bdone; ack_done = v.adone;
        cmd_ready = v.rdy; cond_done = v.cdone; slave_active = v.slv; nak_event = v.nak;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 8'h00, 1'b0, 2'd0, 1'b0);          // R1 reset state
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            check($sformatf("R%0d", TBL[i].req), TBL[i].ectl, TBL[i].ev, TBL[i].ek, TBL[i].earb);
        end
        // R1: reset while a START is being offered
        drive('0);
        ctl_wr = 1; ctl_wdata = 8'hC0; tx_hold_full = 1;
        @(negedge clk);
        ctl_wr = 0;
        @(negedge clk);
        check("R4", 8'hC0, 1'b1, 2'd0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", 8'h00, 1'b0, 2'd0, 1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule